// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Collector

This block gathers interrupts at two levels. On the secondary side, each event source feeds one cell of an identity register. A cell holds up to two occurrences: one visible pending event and one queued behind it. When software clears a bit that has a queued event behind it, the bit reads zero for one clock and then sets itself again. The secondary side forms a single aggregate: the OR over all source bits that still hold any event, queued ones included, and that are enabled.

The primary side does not sample that aggregate as a level. An edge detector turns each rising edge of the aggregate into a one-clock set of the summary bit (bit 0) of the primary identity register. The remaining primary bits are set directly by their own event pulses. A primary enable register chooses the sources that can raise the CPU interrupt. A master enable at the top bit of that register gates the output as a whole.

Software reaches all four registers through a flat write/read port. Both identity registers are write-one-to-clear. A handler can force a fresh summary edge by writing zero to the secondary enable and later restoring it. If any secondary event is still held when the enable comes back, the primary summary bit sets again.

Top module: `irq_cascade_top`

## Requirements
- R1: Reset clears every identity bit, queued event, enable bit and the edge history. After reset all four registers read 0 and `cpu_irq_o` is 0.
- R2: A pulse on `src_evt_i[i]` sets bit i of the secondary identity register (address 0), which reads 1 after the sampling edge. If a second event is queued, a write-one-to-clear of the bit makes it read 0 for the first cycle after the write and 1 again from the next cycle. A second clear then leaves it 0.
- R3: A third event that arrives while a bit already holds a pending and a queued event is dropped. Two clears empty the bit.
- R4: An event that arrives in the same cycle as a clear of its own bit is kept, and the bit still reads 1 after that write.
- R5: The secondary aggregate is the OR over source bits of (holds any event AND secondary enable bit). Primary identity bit 0 (address 2) sets one edge after each rising edge of that aggregate.
- R6: While the aggregate stays high, new secondary events and clears that leave a queued event behind do not set primary bit 0 again after software has cleared it.
- R7: While an event is held, writing 0 to the secondary enable (address 1) and then a nonzero value sets primary bit 0 again.
- R8: A pulse on `nsrc_evt_i[j]` sets primary identity bit j+1. Primary identity bits are write-one-to-clear. A set wins over a clear in the same cycle.
- R9: `cpu_irq_o` is a register loaded each cycle with master AND OR(primary identity AND primary enable). The master enable is bit DATA_W-1 of the primary enable register (address 3). Clearing the master drops the output one cycle later and leaves the primary identity unchanged.
- R10: Register map: 0 = secondary identity (W1C), 1 = secondary enable (RW, SRC_W bits), 2 = primary identity (W1C, NORTH_W bits), 3 = primary enable (RW, bits NORTH_W-1:0 plus bit DATA_W-1). Reads are combinational and unimplemented bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| src_evt_i | input | SRC_W | Secondary event pulses, one per source |
| nsrc_evt_i | input | NORTH_W-1 | Direct primary event pulses for identity bits 1 and up |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select for both read and write |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Combinational read data of the selected register |
| cpu_irq_o | output | 1 | Registered CPU interrupt request |

## Verification
Each result falls due a fixed number of edges after its stimulus. A secondary identity bit changes at the edge that samples the event or the clear. The primary summary bit follows one edge later. `cpu_irq_o` follows one edge after the primary state it reflects. Vector steps therefore wait two idle edges before they read a register and the interrupt line. The directed tests for the re-assertion gap and for a same-cycle event and clear sample the first and the second cycle after the write separately, so the one-cycle low window shows up on its own.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

    typedef enum logic [1:0] {
        RSEL_SOUTH_ID = 2'd0,
        RSEL_SOUTH_EN = 2'd1,
        RSEL_NORTH_ID = 2'd2,
        RSEL_NORTH_EN = 2'd3
    } reg_sel_e;

    // Occupancy of one secondary identity cell: up to two events, plus a
    // flag for the one-cycle low window after a clear that left one queued.
    typedef struct packed {
        logic [1:0] cnt;
        logic       gap;
    } cell_state_t;

    localparam logic [1:0] CELL_DEPTH = 2'd2;

    function automatic logic [1:0] sat_inc(input logic [1:0] c, input logic add);
        if (add && (c < CELL_DEPTH)) return c + 2'd1;
        return c;
    endfunction

    function automatic logic cell_visible(input cell_state_t s);
        return (s.cnt != 2'd0) && !s.gap;
    endfunction

    function automatic logic cell_held(input cell_state_t s);
        return s.cnt != 2'd0;
    endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_cascade_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic evt_i,
    input  logic clr_i,
    output logic pend_o,
    output logic held_o
);

    cell_state_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.gap = 1'b0;
        if (clr_i && cell_visible(st_q)) begin
            if (evt_i) begin
                // one event leaves, the arriving one takes its place
                st_d.cnt = st_q.cnt;
            end else begin
                st_d.cnt = st_q.cnt - 2'd1;
                st_d.gap = (st_q.cnt == CELL_DEPTH);
            end
        end else begin
            st_d.cnt = sat_inc(st_q.cnt, evt_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign pend_o = cell_visible(st_q);
    assign held_o = cell_held(st_q);

    // R2
    gap_reload_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (held_o && !pend_o) |=> pend_o);

    // R4
    same_cycle_keep_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_i && pend_o && evt_i) |=> pend_o);

    // R3
    third_drop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.cnt == CELL_DEPTH && evt_i && !clr_i) |=> (st_q.cnt == CELL_DEPTH));

endmodule

// File: rtl/irq_south_ctrl.sv
module irq_south_ctrl
    import irq_cascade_pkg::*;
#(
    parameter int SRC_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [SRC_W-1:0]  evt_i,
    input  logic              wr_id_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [SRC_W-1:0]  id_o,
    output logic [SRC_W-1:0]  en_o,
    output logic              agg_o
);

    logic [SRC_W-1:0] clr_vec;
    logic [SRC_W-1:0] held_vec;
    logic [SRC_W-1:0] en_q;

    assign clr_vec = {SRC_W{wr_id_i}} & wdata_i[SRC_W-1:0];

    for (genvar gi = 0; gi < SRC_W; gi++) begin : g_cell
        irq_src_cell u_cell (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .evt_i  (evt_i[gi]),
            .clr_i  (clr_vec[gi]),
            .pend_o (id_o[gi]),
            .held_o (held_vec[gi])
        );
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)        en_q <= '0;
        else if (wr_en_i) en_q <= wdata_i[SRC_W-1:0];
    end

    assign en_o  = en_q;
    assign agg_o = |(held_vec & en_q);

    // R7
    en_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_o == '0) |-> !agg_o);

    // R5
    visible_in_agg_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (|(id_o & en_o)) |-> agg_o);

endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det (
    input  logic clk_i,
    input  logic rst_i,
    input  logic level_i,
    output logic rise_o
);

    logic hist_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) hist_q <= 1'b0;
        else       hist_q <= level_i;
    end

    assign rise_o = level_i && !hist_q;

    // R6
    no_rise_while_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (level_i && $past(level_i)) |-> !rise_o);

endmodule

// File: rtl/irq_north_ctrl.sv
module irq_north_ctrl
    import irq_cascade_pkg::*;
#(
    parameter int NORTH_W = 4,
    parameter int DATA_W  = 32
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               sum_set_i,
    input  logic [NORTH_W-2:0] nsrc_evt_i,
    input  logic               wr_id_i,
    input  logic               wr_en_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [NORTH_W-1:0] id_o,
    output logic [NORTH_W-1:0] en_o,
    output logic               master_o,
    output logic               irq_o
);

    localparam int MASTER_BIT = DATA_W - 1;

    logic [NORTH_W-1:0] id_q, set_vec, clr_vec;
    logic [NORTH_W-1:0] en_q;
    logic               master_q;
    logic               irq_q;

    assign set_vec = {nsrc_evt_i, sum_set_i};
    assign clr_vec = {NORTH_W{wr_id_i}} & wdata_i[NORTH_W-1:0];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            id_q     <= '0;
            en_q     <= '0;
            master_q <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            id_q  <= (id_q & ~clr_vec) | set_vec;
            irq_q <= master_q && |(id_q & en_q);
            if (wr_en_i) begin
                en_q     <= wdata_i[NORTH_W-1:0];
                master_q <= wdata_i[MASTER_BIT];
            end
        end
    end

    assign id_o     = id_q;
    assign en_o     = en_q;
    assign master_o = master_q;
    assign irq_o    = irq_q;

    // R9
    master_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !master_o |=> !irq_o);

    // R5
    summary_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(id_o[0]) |-> $past(sum_set_i));

    // R8
    set_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (|set_vec) |=> ((id_o & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/irq_cascade_top.sv
module irq_cascade_top
    import irq_cascade_pkg::*;
#(
    parameter int SRC_W   = 8,
    parameter int NORTH_W = 4,
    parameter int DATA_W  = 32
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [SRC_W-1:0]   src_evt_i,
    input  logic [NORTH_W-2:0] nsrc_evt_i,
    input  logic               reg_wr_i,
    input  logic [1:0]         reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               cpu_irq_o
);

    localparam int SPAD_W = DATA_W - SRC_W;
    localparam int NPAD_W = DATA_W - NORTH_W - 1;

    reg_sel_e           sel;
    logic               wr_sid, wr_sen, wr_nid, wr_nen;
    logic [SRC_W-1:0]   s_id, s_en;
    logic               s_agg, s_rise;
    logic [NORTH_W-1:0] n_id, n_en;
    logic               n_master;

    assign sel    = reg_sel_e'(reg_addr_i);
    assign wr_sid = reg_wr_i && (sel == RSEL_SOUTH_ID);
    assign wr_sen = reg_wr_i && (sel == RSEL_SOUTH_EN);
    assign wr_nid = reg_wr_i && (sel == RSEL_NORTH_ID);
    assign wr_nen = reg_wr_i && (sel == RSEL_NORTH_EN);

    irq_south_ctrl #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u_south (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .evt_i   (src_evt_i),
        .wr_id_i (wr_sid),
        .wr_en_i (wr_sen),
        .wdata_i (reg_wdata_i),
        .id_o    (s_id),
        .en_o    (s_en),
        .agg_o   (s_agg)
    );

    irq_edge_det u_edge (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .level_i (s_agg),
        .rise_o  (s_rise)
    );

    irq_north_ctrl #(.NORTH_W(NORTH_W), .DATA_W(DATA_W)) u_north (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .sum_set_i  (s_rise),
        .nsrc_evt_i (nsrc_evt_i),
        .wr_id_i    (wr_nid),
        .wr_en_i    (wr_nen),
        .wdata_i    (reg_wdata_i),
        .id_o       (n_id),
        .en_o       (n_en),
        .master_o   (n_master),
        .irq_o      (cpu_irq_o)
    );

    always_comb begin
        unique case (sel)
            RSEL_SOUTH_ID: reg_rdata_o = {{SPAD_W{1'b0}}, s_id};
            RSEL_SOUTH_EN: reg_rdata_o = {{SPAD_W{1'b0}}, s_en};
            RSEL_NORTH_ID: reg_rdata_o = {{(DATA_W-NORTH_W){1'b0}}, n_id};
            RSEL_NORTH_EN: reg_rdata_o = {n_master, {NPAD_W{1'b0}}, n_en};
            default:       reg_rdata_o = '0;
        endcase
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i)
        $past(rst_i) |-> (!cpu_irq_o && n_id == '0 && s_en == '0));

endmodule

// File: tb/test_irq_cascade_top.sv
module test_irq_cascade_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  sevt;
    logic [2:0]  nevt;
    logic        wr;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irq_cascade_top #(.SRC_W(8), .NORTH_W(4), .DATA_W(32)) i_irq_cascade_top (
        .clk_i       (clk),
        .rst_i       (rst),
        .src_evt_i   (sevt),
        .nsrc_evt_i  (nevt),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .cpu_irq_o   (irq)
    );

    typedef struct packed {
        logic [7:0]  sevt;
        logic [2:0]  nevt;
        logic        wr;
        logic [1:0]  waddr;
        logic [31:0] wdata;
        logic [1:0]  raddr;
        logic [31:0] rexp;
        logic        irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 3'b000, 1'b1, 2'd1, 32'h0000_00FF, 2'd1, 32'h0000_00FF, 1'b0, 4'd10}, // R10
        '{8'h00, 3'b000, 1'b1, 2'd3, 32'h8000_0001, 2'd3, 32'h8000_0001, 1'b0, 4'd10}, // R10
        '{8'h01, 3'b000, 1'b0, 2'd0, 32'h0,         2'd0, 32'h0000_0001, 1'b1, 4'd2},  // R2
        '{8'h00, 3'b000, 1'b0, 2'd0, 32'h0,         2'd2, 32'h0000_0001, 1'b1, 4'd5},  // R5
        '{8'h00, 3'b000, 1'b1, 2'd2, 32'h0000_0001, 2'd2, 32'h0000_0000, 1'b0, 4'd6},  // R6
        '{8'h02, 3'b000, 1'b0, 2'd0, 32'h0,         2'd2, 32'h0000_0000, 1'b0, 4'd6},  // R6
        '{8'h00, 3'b000, 1'b1, 2'd0, 32'h0000_0003, 2'd0, 32'h0000_0000, 1'b0, 4'd2},  // R2
        '{8'h04, 3'b000, 1'b0, 2'd0, 32'h0,         2'd2, 32'h0000_0001, 1'b1, 4'd5},  // R5
        '{8'h00, 3'b000, 1'b1, 2'd3, 32'h0000_0001, 2'd2, 32'h0000_0001, 1'b0, 4'd9},  // R9
        '{8'h00, 3'b000, 1'b1, 2'd3, 32'h8000_000F, 2'd3, 32'h8000_000F, 1'b1, 4'd9},  // R9
        '{8'h00, 3'b000, 1'b1, 2'd2, 32'h0000_0001, 2'd2, 32'h0000_0000, 1'b0, 4'd6},  // R6
        '{8'h00, 3'b000, 1'b1, 2'd1, 32'h0000_0000, 2'd1, 32'h0000_0000, 1'b0, 4'd7},  // R7
        '{8'h00, 3'b000, 1'b1, 2'd1, 32'h0000_00FF, 2'd2, 32'h0000_0001, 1'b1, 4'd7},  // R7
        '{8'h00, 3'b010, 1'b0, 2'd0, 32'h0,         2'd2, 32'h0000_0005, 1'b1, 4'd8},  // R8
        '{8'h00, 3'b000, 1'b1, 2'd2, 32'h0000_0005, 2'd2, 32'h0000_0000, 1'b0, 4'd8},  // R8
        '{8'h00, 3'b000, 1'b1, 2'd0, 32'h0000_0004, 2'd0, 32'h0000_0000, 1'b0, 4'd2},  // R2
        '{8'h00, 3'b000, 1'b1, 2'd1, 32'h0000_01FF, 2'd1, 32'h0000_00FF, 1'b0, 4'd10}  // R10
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // drive one cycle of stimulus; returns 1 ns after the sampling edge
    task automatic apply(input logic [7:0] s, input logic [2:0] n, input logic w,
                         input logic [1:0] a, input logic [31:0] d);
        sevt = s; nevt = n; wr = w; addr = a; wdata = d;
        @(posedge clk); #1;
        sevt = '0; nevt = '0; wr = 1'b0; wdata = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        addr = a; #0.5; v = rdata;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired, run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; sevt = '0; nevt = '0; wr = 1'b0; addr = '0; wdata = '0;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R1 reset read", v, 32'h0);
        end
        check("R1 reset irq", {31'h0, irq}, 32'h0);

        // vector walk
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].sevt, VECS[i].nevt, VECS[i].wr, VECS[i].waddr, VECS[i].wdata);
            idle(2);
            rd(VECS[i].raddr, v);
            check($sformatf("R%0d vector %0d read", VECS[i].req, i), v, VECS[i].rexp);
            check($sformatf("R%0d vector %0d irq", VECS[i].req, i), {31'h0, irq}, {31'h0, VECS[i].irq});
        end

        // R2 queued event re-asserts one cycle after clear; R6 no new summary
        apply(8'h08, 3'b000, 1'b0, 2'd0, 32'h0);
        apply(8'h08, 3'b000, 1'b0, 2'd0, 32'h0);
        idle(2);
        apply(8'h00, 3'b000, 1'b1, 2'd2, 32'h1);
        apply(8'h00, 3'b000, 1'b1, 2'd0, 32'h08);
        rd(2'd0, v);
        check("R2 low window after clear", v, 32'h00);
        idle(1);
        rd(2'd0, v);
        check("R2 re-asserted from queue", v, 32'h08);
        idle(2);
        rd(2'd2, v);
        check("R6 no summary from queue refill", v, 32'h0);
        apply(8'h00, 3'b000, 1'b1, 2'd0, 32'h08);
        idle(2);
        rd(2'd0, v);
        check("R2 second clear empties", v, 32'h00);

        // R3 third event dropped
        apply(8'h10, 3'b000, 1'b0, 2'd0, 32'h0);
        apply(8'h10, 3'b000, 1'b0, 2'd0, 32'h0);
        apply(8'h10, 3'b000, 1'b0, 2'd0, 32'h0);
        apply(8'h00, 3'b000, 1'b1, 2'd0, 32'h10);
        idle(2);
        rd(2'd0, v);
        check("R3 one event left after first clear", v, 32'h10);
        apply(8'h00, 3'b000, 1'b1, 2'd0, 32'h10);
        idle(2);
        rd(2'd0, v);
        check("R3 third event was dropped", v, 32'h00);

        // R4 event in the same cycle as its clear is kept
        apply(8'h20, 3'b000, 1'b0, 2'd0, 32'h0);
        apply(8'h20, 3'b000, 1'b1, 2'd0, 32'h20);
        rd(2'd0, v);
        check("R4 kept in clear cycle", v, 32'h20);
        idle(1);
        rd(2'd0, v);
        check("R4 still pending", v, 32'h20);
        apply(8'h00, 3'b000, 1'b1, 2'd0, 32'h20);
        idle(2);
        rd(2'd0, v);
        check("R4 cleared afterwards", v, 32'h00);

        // R8 set wins over clear in the same cycle
        apply(8'h00, 3'b001, 1'b1, 2'd2, 32'h2);
        rd(2'd2, v);
        check("R8 set wins", v & 32'h2, 32'h2);

        // R1 reset in mid-run
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(1);
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R1 mid-run reset read", v, 32'h0);
        end
        check("R1 mid-run reset irq", {31'h0, irq}, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule